// File: doc/BRIEF.md
# PCIe PHY Power Sequencer

This block replaces the firmware routine that brings a PCIe PHY out of reset and shuts it down again. It drives the PHY reset line, the lane A idle control and a small configuration port made of a 6-bit address, a 4-bit data field and a write strobe. It reads two status bits from the PHY: PLL locked and PLL output active. All delays and timeouts are counted in clock cycles, and the counts are derived from a clock-frequency parameter.

A power-on request starts a fixed sequence that runs through these named states:
- `ST_REL_RST` releases the PHY reset.
- `ST_LOAD_ADDR` loads configuration address 0x10.
- `ST_LANE_UP` takes lane A out of idle.
- `ST_WAIT_LOCK` waits for PLL lock.
- `ST_WR_SETUP`, `ST_WR_STROBE` and `ST_WR_END` run twice to perform two strobed configuration writes.
- `ST_WAIT_OUT` waits for the PLL output flag to clear.
- `ST_RELOAD` reloads address 0x10.
- `ST_WAIT_RELOCK` waits for lock a second time.

Success ends in `ST_ON`. A timeout in any wait returns the FSM to `ST_OFF` with the PHY held in reset and an error code set. A power-off request accepted in `ST_OFF` or `ST_ON` passes through `ST_OFF_IDLE`, which idles lane A, and then reaches `ST_OFF`, where reset is asserted. Each completion raises a single-cycle `done`.

Top module: `pcie_phy_pwrseq`

## Requirements
- R1: While reset is applied, the outputs take these values: `phy_rst`=1, `lane_a_idle`=1, `cfg_wr`=0, `busy`=0, `done`=0 and `err`=0.
- R2: After an accepted power-on request, the outputs change over three consecutive cycles in this order. First `phy_rst` falls. In the next cycle `cfg_addr` becomes 0x10. In the cycle after that `lane_a_idle` falls.
- R3: Each wait samples its condition on its first cycle and then every POLL_US·CLK_MHZ cycles. The sequence advances on the first sample that meets the condition. The lock waits need `stat_pll_locked`=1 and the output wait needs `stat_pll_out`=0.
- R4: A wait whose condition is still unmet at sample number TIMEOUT_US/POLL_US (counting from 0) fails on that sample.
- R5: There are two configuration writes. The first uses address 0x10 and the second uses address 0x12, and both write data 0x8. Address and data are held for STEP_US·CLK_MHZ cycles before `cfg_wr` rises. `cfg_wr` then stays high for STEP_US·CLK_MHZ cycles and drops for one cycle before the next setup begins.
- R6: After the second write, the block waits for `stat_pll_out`=0. It then reloads `cfg_addr`=0x10 and waits for lock again.
- R7: The `err` codes are 0 for none, 1 for a lock-wait failure, 2 for an output-wait failure and 3 for a relock failure. A failure sets `phy_rst`=1 in the cycle that `done` pulses. `err` holds its value until the next accepted request clears it.
- R8: A successful power-on pulses `done` for one cycle with `err`=0. The PHY stays out of reset and lane A stays active.
- R9: On power-off, `lane_a_idle` rises in the first cycle. In the next cycle `phy_rst` rises together with a `done` pulse and `err`=0.
- R10: `busy` is high from the cycle after a request is accepted until the `done` cycle, where it is low. Requests that arrive while `busy` is high have no effect.
- R11: If both requests arrive in the same cycle while the block is idle, the power-off request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request |
| pwr_off_req | input | 1 | Power-off request |
| stat_pll_locked | input | 1 | PHY status: PLL locked |
| stat_pll_out | input | 1 | PHY status: PLL output flag |
| phy_rst | output | 1 | PHY reset, 1 = held in reset |
| lane_a_idle | output | 1 | Lane A idle control |
| cfg_addr | output | 6 | Configuration address field |
| cfg_data | output | 4 | Configuration data field |
| cfg_wr | output | 1 | Configuration write strobe |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code of the last completed sequence |

## Verification
The assertions assume that both status bits and both request inputs are synchronous to `clk` and change only between rising edges. The bench meets this by driving every input at the falling edge, from a PHY model that reacts to what it observes at the ports. Each request is a single-cycle pulse, so a request held high in `ST_ON` never retriggers a sequence. The sweeps move the arrival of each status condition across every cycle of the window, including the last sample before the timeout and the first cycle after it.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_REL_RST,
        ST_LOAD_ADDR,
        ST_LANE_UP,
        ST_WAIT_LOCK,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_END,
        ST_WAIT_OUT,
        ST_RELOAD,
        ST_WAIT_RELOCK,
        ST_ON,
        ST_OFF_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_LOCK   = 2'd1,
        ERR_OUT    = 2'd2,
        ERR_RELOCK = 2'd3
    } seq_err_e;

    localparam int          ADDR_W        = 6;
    localparam int          DATA_W        = 4;
    localparam logic [5:0]  CFG_ADDR_LOCK = 6'h10;
    localparam logic [5:0]  CFG_ADDR_SCC  = 6'h12;
    localparam logic [3:0]  CFG_DATA_SEL  = 4'h8;

endpackage

// File: rtl/pwrseq_delay.sv
// Counts a fixed number of cycles while run is high; restarts after each expiry.
module pwrseq_delay #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic elapsed
);
    localparam int          W    = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_q;

    assign elapsed = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || elapsed) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_poll.sv
// Periodic status sampler with a sample-count timeout.
module pwrseq_poll #(
    parameter int POLL_CYC = 5000,
    parameter int NPOLL    = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cond,
    output logic pass,
    output logic expire
);
    localparam int           PW      = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int           NW      = $clog2(NPOLL + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(POLL_CYC - 1);
    localparam logic [NW-1:0] N_LAST  = NW'(NPOLL);

    logic [PW-1:0] ph_q;
    logic [NW-1:0] n_q;
    logic          sample;

    assign sample = active && (ph_q == '0);
    assign pass   = sample && cond;
    assign expire = sample && !cond && (n_q == N_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            n_q  <= '0;
        end else if (!active) begin
            ph_q <= '0;
            n_q  <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
            if (n_q != N_LAST) begin
                n_q <= n_q + 1'b1;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcie_phy_pwrseq.sv
module pcie_phy_pwrseq
    import pwrseq_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int STEP_US    = 1,
    parameter int POLL_US    = 50,
    parameter int TIMEOUT_US = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on_req,
    input  logic       pwr_off_req,
    input  logic       stat_pll_locked,
    input  logic       stat_pll_out,
    output logic       phy_rst,
    output logic       lane_a_idle,
    output logic [5:0] cfg_addr,
    output logic [3:0] cfg_data,
    output logic       cfg_wr,
    output logic       busy,
    output logic       done,
    output logic [1:0] err
);
    localparam int STEP_CYC = CLK_MHZ * STEP_US;
    localparam int POLL_CYC = CLK_MHZ * POLL_US;
    localparam int NPOLL    = TIMEOUT_US / POLL_US;

    seq_state_e state_q, state_d;
    logic       wr_idx_q, wr_idx_d;
    logic       fin;
    seq_err_e   fin_err;

    logic       poll_active, poll_cond, poll_pass, poll_expire;
    logic       dly_run, dly_elapsed;

    // wait engine shared by the three polled waits
    assign poll_active = (state_q == ST_WAIT_LOCK) || (state_q == ST_WAIT_OUT) ||
                         (state_q == ST_WAIT_RELOCK);
    assign poll_cond   = (state_q == ST_WAIT_OUT) ? !stat_pll_out : stat_pll_locked;

    pwrseq_poll #(
        .POLL_CYC (POLL_CYC),
        .NPOLL    (NPOLL)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (poll_active),
        .cond   (poll_cond),
        .pass   (poll_pass),
        .expire (poll_expire)
    );

    // setup and strobe timing for configuration writes
    assign dly_run = (state_q == ST_WR_SETUP) || (state_q == ST_WR_STROBE);

    pwrseq_delay #(
        .CYC (STEP_CYC)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (dly_run),
        .elapsed (dly_elapsed)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        wr_idx_d = wr_idx_q;
        fin      = 1'b0;
        fin_err  = ERR_NONE;
        unique case (state_q)
            ST_OFF, ST_ON: begin
                if (pwr_off_req) begin
                    state_d = ST_OFF_IDLE;
                end else if (pwr_on_req) begin
                    state_d = ST_REL_RST;
                end
            end
            ST_REL_RST:   state_d = ST_LOAD_ADDR;
            ST_LOAD_ADDR: state_d = ST_LANE_UP;
            ST_LANE_UP:   state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (poll_pass) begin
                    state_d  = ST_WR_SETUP;
                    wr_idx_d = 1'b0;
                end else if (poll_expire) begin
                    state_d = ST_OFF;
                    fin     = 1'b1;
                    fin_err = ERR_LOCK;
                end
            end
            ST_WR_SETUP: begin
                if (dly_elapsed) begin
                    state_d = ST_WR_STROBE;
                end
            end
            ST_WR_STROBE: begin
                if (dly_elapsed) begin
                    state_d = ST_WR_END;
                end
            end
            ST_WR_END: begin
                if (!wr_idx_q) begin
                    wr_idx_d = 1'b1;
                    state_d  = ST_WR_SETUP;
                end else begin
                    state_d = ST_WAIT_OUT;
                end
            end
            ST_WAIT_OUT: begin
                if (poll_pass) begin
                    state_d = ST_RELOAD;
                end else if (poll_expire) begin
                    state_d = ST_OFF;
                    fin     = 1'b1;
                    fin_err = ERR_OUT;
                end
            end
            ST_RELOAD: state_d = ST_WAIT_RELOCK;
            ST_WAIT_RELOCK: begin
                if (poll_pass) begin
                    state_d = ST_ON;
                    fin     = 1'b1;
                end else if (poll_expire) begin
                    state_d = ST_OFF;
                    fin     = 1'b1;
                    fin_err = ERR_RELOCK;
                end
            end
            ST_OFF_IDLE: begin
                state_d = ST_OFF;
                fin     = 1'b1;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            wr_idx_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            wr_idx_q <= wr_idx_d;
        end
    end

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_rst     <= 1'b1;
            lane_a_idle <= 1'b1;
            cfg_addr    <= '0;
            cfg_data    <= '0;
            cfg_wr      <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            err         <= ERR_NONE;
        end else begin
            done   <= fin;
            cfg_wr <= (state_d == ST_WR_STROBE);
            busy   <= (state_d != ST_OFF) && (state_d != ST_ON);
            if (fin) begin
                err <= fin_err;
            end else if ((state_d == ST_REL_RST) || (state_d == ST_OFF_IDLE)) begin
                err <= ERR_NONE;
            end
            case (state_d)
                ST_REL_RST:            phy_rst     <= 1'b0;
                ST_LOAD_ADDR,
                ST_RELOAD:             cfg_addr    <= CFG_ADDR_LOCK;
                ST_LANE_UP:            lane_a_idle <= 1'b0;
                ST_WR_SETUP: begin
                    cfg_addr <= wr_idx_d ? CFG_ADDR_SCC : CFG_ADDR_LOCK;
                    cfg_data <= CFG_DATA_SEL;
                end
                ST_OFF_IDLE:           lane_a_idle <= 1'b1;
                ST_OFF:                phy_rst     <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_rst,
    input logic       lane_a_idle,
    input logic [5:0] cfg_addr,
    input logic [3:0] cfg_data,
    input logic       cfg_wr,
    input logic       busy,
    input logic       done,
    input logic [1:0] err
);
    a_r5_strobe_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (!phy_rst && busy));

    a_r5_fields_set_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr) |-> ($stable(cfg_addr) && $stable(cfg_data)));

    a_r2_lane_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_a_idle) |-> (!phy_rst && cfg_addr == 6'h10 && busy));

    a_r7_fail_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'd0) |-> phy_rst);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_reset_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst) |-> done);

    a_r9_idle_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_rst) && err == 2'd0) |-> lane_a_idle);
endmodule

bind pcie_phy_pwrseq pwrseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phy_rst     (phy_rst),
    .lane_a_idle (lane_a_idle),
    .cfg_addr    (cfg_addr),
    .cfg_data    (cfg_data),
    .cfg_wr      (cfg_wr),
    .busy        (busy),
    .done        (done),
    .err         (err)
);

// File: tb/pcie_phy_pwrseq_bench.sv
module pcie_phy_pwrseq_bench;
    localparam int CLK_MHZ = 2;
    localparam int STEP_US = 1;
    localparam int POLL_US = 2;
    localparam int TMO_US  = 8;
    localparam int STEP    = CLK_MHZ * STEP_US;
    localparam int P       = CLK_MHZ * POLL_US;
    localparam int N       = TMO_US / POLL_US;
    localparam int NP      = N * P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic       stat_pll_locked = 1'b0, stat_pll_out = 1'b1;
    logic       phy_rst, lane_a_idle, cfg_wr, busy, done;
    logic [5:0] cfg_addr;
    logic [3:0] cfg_data;
    logic [1:0] err;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    pcie_phy_pwrseq #(
        .CLK_MHZ(CLK_MHZ), .STEP_US(STEP_US), .POLL_US(POLL_US), .TIMEOUT_US(TMO_US)
    ) u_pcie_phy_pwrseq (
        .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .stat_pll_locked(stat_pll_locked), .stat_pll_out(stat_pll_out),
        .phy_rst(phy_rst), .lane_a_idle(lane_a_idle), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_wr(cfg_wr), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

    // power-on run; d1/d2/d3 = status arrival delay in each wait
    task automatic run_on(int d1, int d2, int d3, int off_at);
        int exp_err, exp_phase, exp_done_c;
        int phase = 0, c = 0, ndone = 0, done_err = -1, done_phase = -1, done_c = -1;
        int end1 = -1, end2 = -1, pulses = 0, width = 0, low_cnt = 0;
        bit prev_wr = 0, busy_ok = 1;
        exp_err   = (d1 > NP) ? 1 : (d2 > NP) ? 2 : (d3 > NP) ? 3 : 0;
        exp_phase = (exp_err == 0) ? 3 : exp_err;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (t == 1) begin
                chk("R2", "reset released first", int'(phy_rst), 0);
                chk("R2", "lane idle at release", int'(lane_a_idle), 1);
            end
            if (t == 2) begin
                chk("R2", "addr loaded second", int'(cfg_addr), 16);
                chk("R2", "lane idle at addr load", int'(lane_a_idle), 1);
                chk("R7", "err cleared on accept", int'(err), 0);
            end
            if (t == 3) chk("R2", "lane active third", int'(lane_a_idle), 0);
            if (off_at >= 0 && t == off_at + 2) begin
                chk("R10", "off ignored lane", int'(lane_a_idle), 0);
                chk("R10", "off ignored reset", int'(phy_rst), 0);
            end
            if (t >= 1 && !done && !busy) busy_ok = 0;
            if (phase == 0 && !lane_a_idle) begin
                phase = 1;
                c = 0;
            end else if (phase > 0) begin
                c++;
            end
            if (!cfg_wr) low_cnt++;
            if (cfg_wr) width++;
            if (cfg_wr && !prev_wr) begin
                pulses++;
                if (pulses == 1) begin
                    end1 = c - STEP;
                    chk("R5", "write 1 addr", int'(cfg_addr), 16);
                end else begin
                    chk("R5", "write 2 addr", int'(cfg_addr), 18);
                    chk("R5", "gap before write 2", low_cnt, 1 + STEP);
                end
                chk("R5", "write data", int'(cfg_data), 8);
            end
            if (!cfg_wr && prev_wr) begin
                chk("R5", "strobe width", width, STEP);
                width = 0;
                low_cnt = 1;
                if (pulses == 2) begin
                    phase = 2;
                    c = 0;
                end
            end
            prev_wr = cfg_wr;
            if (phase == 2 && cfg_addr == 6'h10) begin
                end2 = c;
                phase = 3;
                c = 0;
            end
            if (done) begin
                ndone++;
                done_err = int'(err);
                done_phase = phase;
                done_c = c;
                chk("R10", "busy low at done", int'(busy), 0);
                chk("R7", "reset state at done", int'(phy_rst), (exp_err != 0) ? 1 : 0);
                break;
            end
            pwr_on_req  = (t == 0);
            pwr_off_req = (t == off_at);
            stat_pll_locked = (phase == 1 && c >= 1 + d1) || (phase == 3 && c >= 1 + d3);
            stat_pll_out    = (phase == 2) ? (c < 1 + d2) : (phase < 2);
        end
        pwr_on_req = 0;
        pwr_off_req = 0;
        stat_pll_locked = 0;
        stat_pll_out = 1;
        chk("R8", "one done pulse", ndone, 1);
        chk("R7", "error code", done_err, exp_err);
        chk("R4", "failing wait", done_phase, exp_phase);
        exp_done_c = (exp_err != 0) ? 2 + NP : 2 + ceil_div(d3, P) * P;
        chk((exp_err != 0) ? "R4" : "R6", "done timing", done_c, exp_done_c);
        if (exp_err != 1) begin
            chk("R3", "lock wait exit", end1, 2 + ceil_div(d1, P) * P);
            chk("R5", "write count", pulses, 2);
        end else begin
            chk("R4", "no writes after lock fail", pulses, 0);
        end
        if (exp_err == 0 || exp_err == 3)
            chk("R6", "output wait exit", end2, 2 + ceil_div(d2, P) * P);
        chk("R10", "busy through run", int'(busy_ok), 1);
        @(negedge clk);
        chk("R7", "done is one cycle", int'(done), 0);
        chk("R7", "err held", int'(err), exp_err);
        if (exp_err == 0) begin
            chk("R8", "phy out of reset", int'(phy_rst), 0);
            chk("R8", "lane active", int'(lane_a_idle), 0);
        end
    endtask

    task automatic run_off(bit both);
        int rst_before;
        rst_before = int'(phy_rst);
        @(negedge clk);
        pwr_off_req = 1;
        pwr_on_req  = both;
        @(negedge clk);
        pwr_off_req = 0;
        pwr_on_req  = 0;
        chk(both ? "R11" : "R9", "lane idled first", int'(lane_a_idle), 1);
        chk(both ? "R11" : "R9", "reset unchanged first", int'(phy_rst), rst_before);
        chk("R10", "busy during off", int'(busy), 1);
        chk("R9", "no done yet", int'(done), 0);
        @(negedge clk);
        chk("R9", "reset asserted", int'(phy_rst), 1);
        chk("R9", "done pulse", int'(done), 1);
        chk("R9", "err none", int'(err), 0);
        chk("R9", "busy cleared", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "phy_rst in reset", int'(phy_rst), 1);
        chk("R1", "lane idle in reset", int'(lane_a_idle), 1);
        chk("R1", "strobe in reset", int'(cfg_wr), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "err in reset", int'(err), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        for (int d = 0; d <= NP + 2; d++) begin
            run_on(d, 0, 0, -1);
            run_off(1'b0);
        end
        for (int d = 0; d <= NP + 2; d++) begin
            run_on(3, d, 0, -1);
            run_off(1'b0);
        end
        for (int d = 0; d <= NP + 2; d++) begin
            run_on(0, 5, d, -1);
            run_off(1'b0);
        end
        run_on(10, 2, 2, 6);
        run_off(1'b1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule